// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the software-facing register bank of one DMA channel. A host reaches it over a simple memory-mapped bus that completes each read or write in a single cycle. Three registers are visible.

The operation register takes command strobes. Start, stop-after-drain, abort and FIFO reset leave the bank as one-cycle pulses toward the channel datapath. Two further strobes clear the sticky completion flags, and one more resets the channel's status.

The control register holds the interrupt enables. There is one global enable and seven per-event enables. Each enable has its own set bit and its own clear bit, so software can change one enable without reading the others first. The status register shows the event flags and a summary interrupt bit. It also holds a two-bit error code for each of the link, memory and device sides, plus a transfer-error flag that is the OR of the three codes.

The datapath drives the event and error inputs. The `irq` output follows the summary bit.

Top module: `dma_chan_regs`

## Requirements
- R1: Writing the control register with the set bit of a pair at 1 turns that enable on. Pair k (k = 0..6 for the events, k = 7 for the global enable) has its set bit at 17+2k and its clear bit at 16+2k. A control read returns each enable at its set-bit position and 0 in every other bit.
- R2: A bit written as 0 in the control register leaves its enable unchanged.
- R3: When both bits of a pair are written as 1, the enable ends up off.
- R4: An operation-register write pulses each outbound strobe for exactly one cycle, on the cycle after the write. The strobes are bit 0 start, bit 2 stop, bit 3 abort and bit 4 FIFO reset. A write with the bit at 0 gives no pulse.
- R5: The done flag (event 4, status bit 25) and the link-complete flag (event 1, status bit 19) are sticky. Operation bit 7 clears done and bit 5 clears link-complete. Neither clear touches the other flag. An event that arrives in the same cycle as its clear keeps the flag set.
- R6: The other five event flags show their inputs one cycle late. These are event 0 continue/ring (bit 17), event 2 device-ready (bit 21), event 3 memory-ready (bit 23), event 5 SAR (bit 27) and event 6 link-pause (bit 29).
- R7: Each side's error code sits in a status field: link in [5:4], memory in [3:2], device in [1:0]. The codes are 1 bus, 2 retry and 3 other. The first nonzero report on a side is held, and later reports on that side are ignored. Bit 9 is 1 whenever any code is nonzero.
- R8: Status bit 31 and `irq` are 1 exactly when the global enable is on and at least one event flag has its enable on.
- R9: Operation bit 31 clears all event flags and error codes in the cycle of the write, and this beats any same-cycle report. The enables are left as they were.
- R10: Bus writes to the status register change nothing, and the operation register reads as 0.
- R11: After reset all enables, flags, error codes, strobes and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word index: 0 operation, 1 control, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_in | input | 7 | Event reports from the datapath, one bit per event |
| err_lnk | input | 2 | Link-side error report, 0 means none |
| err_mem | input | 2 | Memory-side error report |
| err_dev | input | 2 | Device-side error report |
| start_pls | output | 1 | Start strobe |
| stop_pls | output | 1 | Stop-after-drain strobe |
| abort_pls | output | 1 | Abort strobe |
| fifo_rst_pls | output | 1 | FIFO reset strobe |
| irq | output | 1 | Channel interrupt |

## Verification
A wrong enable shows up on the very next control read. A missed sticky hold or a missed clear shows up on the first status read after the event or the command. An error code that is latched wrongly stays wrong until a channel reset, so a read that comes several cycles later still exposes it. A wrong interrupt gate is visible on `irq` in the same cycle the flag or enable changes. Strobe faults show up one cycle after the write, as a missing pulse, an extra pulse or a pulse that lasts too long.

// File: rtl/dmachan_pkg.sv
// Shared bit positions and types for the DMA channel register bank.
// Assumes a 32-bit register layout; event k sits at status/set bit 17+2k.
package dmachan_pkg;
    localparam int DW       = 32;
    localparam int N_EV     = 7;
    localparam int EV_BASE  = 17;
    localparam int N_PAIR   = N_EV + 1;

    localparam int EV_CONT   = 0;
    localparam int EV_LC     = 1;
    localparam int EV_DRDY   = 2;
    localparam int EV_MRDY   = 3;
    localparam int EV_DONE   = 4;
    localparam int EV_SAR    = 5;
    localparam int EV_LPAUSE = 6;

    localparam int OPB_START    = 0;
    localparam int OPB_STOP     = 2;
    localparam int OPB_ABORT    = 3;
    localparam int OPB_FRST     = 4;
    localparam int OPB_CLR_LC   = 5;
    localparam int OPB_CLR_DONE = 7;
    localparam int OPB_CHRST    = 31;

    localparam int STB_SUM  = 31;
    localparam int STB_XFER = 9;
    localparam int LERR_LSB = 4;
    localparam int MERR_LSB = 2;
    localparam int DERR_LSB = 0;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_BUS   = 2'd1,
        ERR_RETRY = 2'd2,
        ERR_OTHER = 2'd3
    } err_code_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic abort;
        logic fifo_rst;
        logic clr_lc;
        logic clr_done;
        logic chan_rst;
    } cmd_t;
endpackage

// File: rtl/dmachan_cmd.sv
// Operation-register decoder. Turns one write into the command bits
// at once (for in-bank clears) and registers the four outbound strobes
// so each is a one-cycle pulse on the cycle after the write.
// Assumes wr_op is high for one cycle per write.
module dmachan_cmd
    import dmachan_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_op,
    input  logic [W-1:0] wdata,
    output cmd_t         cmd_now,
    output logic         start_pls,
    output logic         stop_pls,
    output logic         abort_pls,
    output logic         fifo_rst_pls
);
    // Decode the command bits of the current write.
    always_comb begin
        cmd_now          = '0;
        cmd_now.start    = wr_op & wdata[OPB_START];
        cmd_now.stop     = wr_op & wdata[OPB_STOP];
        cmd_now.abort    = wr_op & wdata[OPB_ABORT];
        cmd_now.fifo_rst = wr_op & wdata[OPB_FRST];
        cmd_now.clr_lc   = wr_op & wdata[OPB_CLR_LC];
        cmd_now.clr_done = wr_op & wdata[OPB_CLR_DONE];
        cmd_now.chan_rst = wr_op & wdata[OPB_CHRST];
    end

    // Register outbound strobes as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pls    <= 1'b0;
            stop_pls     <= 1'b0;
            abort_pls    <= 1'b0;
            fifo_rst_pls <= 1'b0;
        end else begin
            start_pls    <= cmd_now.start;
            stop_pls     <= cmd_now.stop;
            abort_pls    <= cmd_now.abort;
            fifo_rst_pls <= cmd_now.fifo_rst;
        end
    end
endmodule

// File: rtl/dmachan_ie.sv
// Interrupt-enable bank with per-enable set and clear bits.
// Pair k: set bit BASE+2k, clear bit BASE+2k-1; clear wins; 0 = no change.
// Assumes BASE+2*(NP-1) < W.
module dmachan_ie
    import dmachan_pkg::*;
#(
    parameter int W    = DW,
    parameter int NP   = N_PAIR,
    parameter int BASE = EV_BASE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_ctrl,
    input  logic [W-1:0]  wdata,
    output logic [NP-1:0] en_q,
    output logic [W-1:0]  rd_word
);
    for (genvar k = 0; k < NP; k++) begin : g_pair
        localparam int SB = BASE + 2 * k;
        localparam int CB = SB - 1;

        // Update one enable from its set/clear pair.
        always_ff @(posedge clk) begin
            if (!rst_n)                      en_q[k] <= 1'b0;
            else if (wr_ctrl && wdata[CB])   en_q[k] <= 1'b0;
            else if (wr_ctrl && wdata[SB])   en_q[k] <= 1'b1;
        end
    end

    // Place each enable at its set-bit position for readback.
    always_comb begin
        rd_word = '0;
        for (int k = 0; k < NP; k++) rd_word[BASE + 2 * k] = en_q[k];
    end
endmodule

// File: rtl/dmachan_stat.sv
// Status tracker: event flags (sticky or level-following per STICKY),
// per-side first-error capture, summary interrupt and status word.
// Assumes clears and channel reset are single-cycle strobes.
module dmachan_stat
    import dmachan_pkg::*;
#(
    parameter int           W      = DW,
    parameter int           NE     = N_EV,
    parameter logic [NE-1:0] STICKY = NE'((1 << EV_DONE) | (1 << EV_LC))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] ev_in,
    input  logic [NE-1:0] clr_ev,
    input  logic          chan_rst,
    input  logic [1:0]    err_lnk,
    input  logic [1:0]    err_mem,
    input  logic [1:0]    err_dev,
    input  logic [NE-1:0] en_ev,
    input  logic          en_glb,
    output logic [NE-1:0] flag_q,
    output err_code_e     lnk_q,
    output err_code_e     mem_q,
    output err_code_e     dev_q,
    output logic          irq,
    output logic [W-1:0]  stat_word
);
    for (genvar k = 0; k < NE; k++) begin : g_ev
        if (STICKY[k]) begin : g_sticky
            // Hold the flag until its clear; a same-cycle event wins.
            always_ff @(posedge clk) begin
                if (!rst_n || chan_rst) flag_q[k] <= 1'b0;
                else                    flag_q[k] <= ev_in[k] | (flag_q[k] & ~clr_ev[k]);
            end
        end else begin : g_level
            // Follow the event input one cycle late.
            always_ff @(posedge clk) begin
                if (!rst_n || chan_rst) flag_q[k] <= 1'b0;
                else                    flag_q[k] <= ev_in[k];
            end
        end
    end

    // Keep the first nonzero error code of each side.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            lnk_q <= ERR_NONE;
            mem_q <= ERR_NONE;
            dev_q <= ERR_NONE;
        end else begin
            if (lnk_q == ERR_NONE) lnk_q <= err_code_e'(err_lnk);
            if (mem_q == ERR_NONE) mem_q <= err_code_e'(err_mem);
            if (dev_q == ERR_NONE) dev_q <= err_code_e'(err_dev);
        end
    end

    // Gate enabled events with the global enable.
    assign irq = en_glb & |(flag_q & en_ev);

    // Assemble the status word.
    always_comb begin
        stat_word = '0;
        for (int k = 0; k < NE; k++) stat_word[EV_BASE + 2 * k] = flag_q[k];
        stat_word[STB_SUM]             = irq;
        stat_word[STB_XFER]            = (lnk_q != ERR_NONE) | (mem_q != ERR_NONE) | (dev_q != ERR_NONE);
        stat_word[LERR_LSB +: 2]       = lnk_q;
        stat_word[MERR_LSB +: 2]       = mem_q;
        stat_word[DERR_LSB +: 2]       = dev_q;
    end
endmodule

// File: rtl/dma_chan_regs.sv
// DMA channel register bank top: address decode, read mux, and the
// command, enable and status sub-blocks. Single-cycle bus, reads are
// combinational on bus_addr. Synchronous active-low reset.
module dma_chan_regs
    import dmachan_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int OP_IDX   = 0,
    parameter int CTRL_IDX = 1,
    parameter int STAT_IDX = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [N_EV-1:0]   ev_in,
    input  logic [1:0]        err_lnk,
    input  logic [1:0]        err_mem,
    input  logic [1:0]        err_dev,
    output logic              start_pls,
    output logic              stop_pls,
    output logic              abort_pls,
    output logic              fifo_rst_pls,
    output logic              irq
);
    logic              wr_op, wr_ctrl;
    cmd_t              cmd_now;
    logic [N_PAIR-1:0] en_q;
    logic [DW-1:0]     ctrl_word, stat_word;
    logic [N_EV-1:0]   flag_q, clr_ev;
    err_code_e         lnk_q, mem_q, dev_q;

    // Decode writes per register; status writes are dropped.
    assign wr_op   = bus_wr && (bus_addr == ADDR_W'(OP_IDX));
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_IDX));

    dmachan_cmd #(.W(DW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_op(wr_op), .wdata(bus_wdata),
        .cmd_now(cmd_now), .start_pls(start_pls), .stop_pls(stop_pls),
        .abort_pls(abort_pls), .fifo_rst_pls(fifo_rst_pls)
    );

    dmachan_ie #(.W(DW), .NP(N_PAIR), .BASE(EV_BASE)) u_ie (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
        .en_q(en_q), .rd_word(ctrl_word)
    );

    // Route clear commands to their event positions.
    always_comb begin
        clr_ev          = '0;
        clr_ev[EV_LC]   = cmd_now.clr_lc;
        clr_ev[EV_DONE] = cmd_now.clr_done;
    end

    dmachan_stat #(.W(DW), .NE(N_EV)) u_stat (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .clr_ev(clr_ev),
        .chan_rst(cmd_now.chan_rst), .err_lnk(err_lnk), .err_mem(err_mem),
        .err_dev(err_dev), .en_ev(en_q[N_EV-1:0]), .en_glb(en_q[N_EV]),
        .flag_q(flag_q), .lnk_q(lnk_q), .mem_q(mem_q), .dev_q(dev_q),
        .irq(irq), .stat_word(stat_word)
    );

    // Select read data by word index; the operation register reads 0.
    always_comb begin
        if (bus_addr == ADDR_W'(CTRL_IDX))      bus_rdata = ctrl_word;
        else if (bus_addr == ADDR_W'(STAT_IDX)) bus_rdata = stat_word;
        else                                    bus_rdata = '0;
    end
endmodule

// File: rtl/dma_chan_regs_chk.sv
// Property checker for dma_chan_regs, bound to every instance.
module dma_chan_regs_chk
    import dmachan_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input cmd_t              cmd_now,
    input logic              wr_ctrl,
    input logic [DW-1:0]     bus_wdata,
    input logic [N_PAIR-1:0] en_q,
    input logic [N_EV-1:0]   flag_q,
    input logic [1:0]        lnk_q,
    input logic [1:0]        mem_q,
    input logic [1:0]        dev_q,
    input logic              start_pls,
    input logic              irq
);
    // R4: a start pulse only follows a start command
    a_r4_start_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        start_pls |-> $past(cmd_now.start));

    // R3: writing both global bits leaves the global enable off
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[31] && bus_wdata[30]) |=> !en_q[N_EV]);

    // R5: done stays set unless cleared or channel reset
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[EV_DONE] && !cmd_now.clr_done && !cmd_now.chan_rst) |=> flag_q[EV_DONE]);

    // R9: channel reset empties flags and error codes
    a_r9_chan_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_now.chan_rst |=> (flag_q == '0 && lnk_q == 2'd0 && mem_q == 2'd0 && dev_q == 2'd0));

    // R9: channel reset leaves the enables alone
    a_r9_keep_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_now.chan_rst && !wr_ctrl) |=> $stable(en_q));

    // R7: a held memory-side code only changes on channel reset
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_q != 2'd0 && !cmd_now.chan_rst) |=> $stable(mem_q));

    // R8: no interrupt without the global enable
    a_r8_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> en_q[N_EV]);
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_now(cmd_now), .wr_ctrl(wr_ctrl),
    .bus_wdata(bus_wdata), .en_q(en_q), .flag_q(flag_q),
    .lnk_q(lnk_q), .mem_q(mem_q), .dev_q(dev_q),
    .start_pls(start_pls), .irq(irq)
);

// File: tb/tb_dma_chan_regs.sv
// Directed bench for dma_chan_regs: one task per scenario.
module tb_dma_chan_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  ev_in = '0;
    logic [1:0]  err_lnk = '0, err_mem = '0, err_dev = '0;
    logic        start_pls, stop_pls, abort_pls, fifo_rst_pls, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    localparam logic [1:0] A_OP = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2;

    always #2 clk = ~clk;

    dma_chan_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_in(ev_in),
        .err_lnk(err_lnk), .err_mem(err_mem), .err_dev(err_dev),
        .start_pls(start_pls), .stop_pls(stop_pls), .abort_pls(abort_pls),
        .fifo_rst_pls(fifo_rst_pls), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_ev(input int k);
        @(negedge clk); ev_in[k] = 1'b1;
        @(negedge clk); ev_in[k] = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(A_CTRL, d); check("R11 ctrl", d, 32'h0);
        bus_read(A_STAT, d); check("R11 status", d, 32'h0);
        check("R11 strobes/irq", {27'd0, start_pls, stop_pls, abort_pls, fifo_rst_pls, irq}, 32'h0);
    endtask

    task automatic t_enables;
        logic [31:0] d;
        bus_write(A_CTRL, 32'h0200_0000);
        bus_read(A_CTRL, d); check("R1 set done enable", d, 32'h0200_0000);
        bus_write(A_CTRL, 32'h0008_0000);
        bus_read(A_CTRL, d); check("R2 zeros keep others", d, 32'h0208_0000);
        bus_write(A_CTRL, 32'h0300_0000);
        bus_read(A_CTRL, d); check("R3 clear wins", d, 32'h0008_0000);
        bus_write(A_CTRL, 32'h0004_0000);
        bus_read(A_CTRL, d); check("R1 clear lc enable", d, 32'h0);
    endtask

    task automatic t_cmds;
        bus_write(A_OP, 32'h1);
        check("R4 start pulse", {28'd0, start_pls, stop_pls, abort_pls, fifo_rst_pls}, 32'h8);
        @(negedge clk);
        check("R4 start one cycle", {28'd0, start_pls, stop_pls, abort_pls, fifo_rst_pls}, 32'h0);
        bus_write(A_OP, 32'h1C);
        check("R4 stop/abort/fifo", {28'd0, start_pls, stop_pls, abort_pls, fifo_rst_pls}, 32'h7);
        @(negedge clk);
        check("R4 pulses end", {28'd0, start_pls, stop_pls, abort_pls, fifo_rst_pls}, 32'h0);
    endtask

    task automatic t_sticky;
        logic [31:0] d;
        pulse_ev(4); pulse_ev(1);
        repeat (3) @(negedge clk);
        bus_read(A_STAT, d); check("R5 done+lc held", d, 32'h020A_0000 & 32'h0208_0000);
        bus_write(A_OP, 32'h20);
        bus_read(A_STAT, d); check("R5 lc clear keeps done", d, 32'h0200_0000);
        bus_write(A_OP, 32'h80);
        bus_read(A_STAT, d); check("R5 done cleared", d, 32'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_OP; bus_wdata = 32'h80; ev_in[4] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; ev_in[4] = 1'b0;
        bus_read(A_STAT, d); check("R5 event beats clear", d, 32'h0200_0000);
        bus_write(A_OP, 32'h80);
    endtask

    task automatic t_level;
        logic [31:0] d;
        @(negedge clk); ev_in[3] = 1'b1; ev_in[6] = 1'b1;
        @(negedge clk);
        bus_read(A_STAT, d); check("R6 mrdy+lpause follow", d, 32'h2080_0000);
        ev_in[3] = 1'b0; ev_in[6] = 1'b0;
        @(negedge clk);
        bus_read(A_STAT, d); check("R6 flags drop", d, 32'h0);
    endtask

    task automatic t_err;
        logic [31:0] d;
        @(negedge clk); err_mem = 2'd2;
        @(negedge clk); err_mem = 2'd3; err_lnk = 2'd1;
        @(negedge clk); err_mem = 2'd0; err_lnk = 2'd3;
        @(negedge clk); err_lnk = 2'd0;
        bus_read(A_STAT, d); check("R7 first codes held", d, 32'h0000_0218);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        bus_write(A_CTRL, 32'h8200_0000);
        check("R8 no flag no irq", {31'd0, irq}, 32'h0);
        pulse_ev(4);
        bus_read(A_STAT, d); check("R8 summary bit", d & 32'h8200_0000, 32'h8200_0000);
        check("R8 irq high", {31'd0, irq}, 32'h1);
        bus_write(A_CTRL, 32'h4000_0000);
        check("R8 global off", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_chrst;
        logic [31:0] d;
        bus_write(A_OP, 32'h8000_0000);
        bus_read(A_STAT, d); check("R9 status cleared", d, 32'h0);
        bus_read(A_CTRL, d); check("R9 enables kept", d, 32'h0200_0000);
    endtask

    task automatic t_ignored;
        logic [31:0] d;
        pulse_ev(1);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_read(A_STAT, d); check("R10 status write ignored", d, 32'h0008_0000);
        bus_read(A_CTRL, d); check("R10 ctrl untouched", d, 32'h0200_0000);
        bus_read(A_OP, d); check("R10 op reads zero", d, 32'h0);
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables();
        t_cmds();
        t_sticky();
        t_level();
        t_err();
        t_irq();
        t_chrst();
        t_ignored();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule